// File: doc/BRIEF.md
# Partial-Scan Test Sequencer with Mixed-Flop Core

This block holds a small sequential core in which only some of the flip-flops sit on a serial scan chain, together with the controller that runs a complete partial-scan test on it. The core has two kinds of state. The chain flops have a multiplexed data input and are advanced by a scan clock enable. The remaining flops are advanced only by the functional clock enable, so they keep their value whenever the chain shifts.

A single `start` pulse launches the run. The controller first shifts a chain-flush pattern through the chain. Then, for each test vector, it loads the chain state serially and applies one capture cycle. In that cycle both enables are active and the vector's primary-input word drives the core. The response captured by one vector leaves the chain while the next vector is loaded, so only one trailing unload is needed after the last vector. The test vectors come from an internal table that is computed from the vector index. A cycle counter is available at the ports so that the length of the run can be checked against its closed-form value.

Top module: `pscan_test_top`

## Requirements
- R1: While reset is high and after it is released, `done`, `busy`, both clock enables, `test_sel`, `chain_in`, `pi_drive`, `scan_out`, `hold_q` and `cycle_cnt` are all zero.
- R2: After `start` is sampled in the idle state, the first NSFF+4 active cycles flush the chain. `scan_clk_en`=1, `func_clk_en`=0, `test_sel`=1, and `chain_in` at flush step k equals bit 1 of k, which gives 0,0,1,1 repeating.
- R3: In every cycle where `func_clk_en` is 0, the non-scanned state `hold_q` keeps its value.
- R4: On each shift (`scan_clk_en`=1, `test_sel`=1), chain bit i moves to bit i+1 and `chain_in` enters bit 0. `scan_out` always shows the top chain bit (index NSFF-1).
- R5: Vector v is loaded in NSFF shift cycles. Its scan word is the low NSFF bits of v*157+53, and `chain_in` presents it top bit first.
- R6: Each load is followed by exactly one capture cycle with `scan_clk_en`=1, `func_clk_en`=1 and `test_sel`=0. In that cycle `pi_drive` holds P = low NPI bits of v*41+7, otherwise `pi_drive` is zero. At the capture edge, chain bit i becomes c[(i+1)%NSFF]^P[i%NPI]^h[i%NNS] and held bit j becomes h[j]^P[j%NPI]^c[j%NSFF], where c and h are the values just before the edge.
- R7: The response of vector v leaves on `scan_out` while vector v+1 is loaded. The response of the last vector leaves during a trailing unload of NSFF cycles, in which `chain_in` is 0.
- R8: A run is (NVEC+2)*NSFF+NVEC+4 cycles long. `cycle_cnt` equals the number of active cycles already completed. When `done` rises it equals the total, and it then holds.
- R9: A `start` pulse while `busy` is 1 has no effect on the sequence or on the count.
- R10: `start` in the done state begins a new run with `cycle_cnt` reset to 0. The non-scanned state keeps the value left by the previous run.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Launch a test run (idle or done state only) |
| done | output | 1 | Run finished, held until the next start |
| busy | output | 1 | A run is in progress |
| scan_clk_en | output | 1 | Clock enable of the chain flops |
| func_clk_en | output | 1 | Clock enable of the non-scanned flops |
| test_sel | output | 1 | 1 selects the serial input of the chain flops |
| chain_in | output | 1 | Serial bit driven into chain bit 0 |
| scan_out | output | 1 | Top chain bit |
| pi_drive | output | NPI | Primary-input word applied to the core |
| hold_q | output | NNS | Non-scanned flop state |
| cycle_cnt | output | CW | Active cycles completed in the current run |

## Verification
`start` is sampled on a rising edge, and the first flush cycle is the very next cycle. The enables, `test_sel`, `chain_in` and `pi_drive` are decoded from the sequencer state, so they are due in the same cycle as the step they belong to. `scan_out`, `hold_q` and `cycle_cnt` change only one edge after the shift or capture that causes them. The bench steps a model of the chain and the held flops once per active cycle. It compares every output at the falling edge before the edge that advances the model, which places the effect of each capture exactly one cycle after its control cycle. `done` is checked at the falling edge after the last unload shift.

// File: rtl/pscan_pkg.sv
`timescale 1ns/1ps
package pscan_pkg;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_FLUSH,
    ST_LOAD,
    ST_CAPT,
    ST_UNLOAD,
    ST_DONE
  } seq_state_t;

  localparam int unsigned FLUSH_EXTRA = 4;
  localparam int unsigned SCAN_MUL    = 157;
  localparam int unsigned SCAN_ADD    = 53;
  localparam int unsigned PI_MUL      = 41;
  localparam int unsigned PI_ADD      = 7;

  function automatic int unsigned test_len(int unsigned n_chain, int unsigned n_vec);
    return (n_vec + 2) * n_chain + n_vec + FLUSH_EXTRA;
  endfunction

endpackage

// File: rtl/pscan_vec_rom.sv
`timescale 1ns/1ps
module pscan_vec_rom
  import pscan_pkg::*;
#(
  parameter int unsigned NVEC = 5,
  parameter int unsigned NSFF = 8,
  parameter int unsigned NPI  = 4,
  parameter int unsigned IW   = 3
) (
  input  logic [IW-1:0]   idx,
  output logic [NSFF-1:0] scan_word,
  output logic [NPI-1:0]  pi_word
);

  logic [NSFF-1:0] scan_mem [NVEC];
  logic [NPI-1:0]  pi_mem   [NVEC];

  // Constant table, one entry per vector, computed from the index
  for (genvar g = 0; g < NVEC; g++) begin : g_entry
    assign scan_mem[g] = NSFF'(g * SCAN_MUL + SCAN_ADD);
    assign pi_mem[g]   = NPI'(g * PI_MUL + PI_ADD);
  end

  always_comb begin
    scan_word = '0;
    pi_word   = '0;
    if (int'(idx) < NVEC) begin
      scan_word = scan_mem[idx];
      pi_word   = pi_mem[idx];
    end
  end

endmodule

// File: rtl/pscan_cut.sv
`timescale 1ns/1ps
module pscan_cut #(
  parameter int unsigned NSFF = 8,
  parameter int unsigned NNS  = 4,
  parameter int unsigned NPI  = 4
) (
  input  logic           clk,
  input  logic           rst,
  input  logic           scan_en,
  input  logic           func_en,
  input  logic           tsel,
  input  logic           sin,
  input  logic [NPI-1:0] pi,
  output logic           scan_out,
  output logic [NNS-1:0] hold_q
);

  logic [NSFF-1:0] sc_q, sc_func, sc_shift;
  logic [NNS-1:0]  ns_q, ns_func;

  // Functional next state of the chain flops
  for (genvar i = 0; i < NSFF; i++) begin : g_sc_next
    assign sc_func[i] = sc_q[(i + 1) % NSFF] ^ pi[i % NPI] ^ ns_q[i % NNS];
  end

  // Functional next state of the non-scanned flops
  for (genvar j = 0; j < NNS; j++) begin : g_ns_next
    assign ns_func[j] = ns_q[j] ^ pi[j % NPI] ^ sc_q[j % NSFF];
  end

  if (NSFF > 1) begin : g_long
    assign sc_shift = {sc_q[NSFF-2:0], sin};
  end else begin : g_single
    assign sc_shift = sin;
  end

  // Chain flops: mux between serial and functional input, scan clock enable
  always_ff @(posedge clk) begin
    if (rst)          sc_q <= '0;
    else if (scan_en) sc_q <= tsel ? sc_shift : sc_func;
  end

  // Non-scanned flops: functional clock enable only
  always_ff @(posedge clk) begin
    if (rst)          ns_q <= '0;
    else if (func_en) ns_q <= ns_func;
  end

  assign scan_out = sc_q[NSFF-1];
  assign hold_q   = ns_q;

  // R3
  ns_hold_chk: assert property (@(posedge clk) disable iff (rst)
    !func_en |=> $stable(ns_q));

  // R4
  shift_entry_chk: assert property (@(posedge clk) disable iff (rst)
    (scan_en && tsel) |=> sc_q[0] == $past(sin));

endmodule

// File: rtl/pscan_seq.sv
`timescale 1ns/1ps
module pscan_seq
  import pscan_pkg::*;
#(
  parameter int unsigned NSFF = 8,
  parameter int unsigned NVEC = 5,
  parameter int unsigned CW   = 7,
  parameter int unsigned SW   = 4,
  parameter int unsigned IW   = 3
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            start,
  input  logic [NSFF-1:0] vec_scan,
  output logic [IW-1:0]   vec_idx,
  output logic            scan_en,
  output logic            func_en,
  output logic            tsel,
  output logic            chain_bit,
  output logic            done,
  output logic            busy,
  output logic [CW-1:0]   cycle_cnt
);

  localparam logic [SW-1:0] FLUSH_LAST = SW'(NSFF + FLUSH_EXTRA - 1);
  localparam logic [SW-1:0] SHIFT_LAST = SW'(NSFF - 1);
  localparam logic [IW-1:0] VEC_LAST   = IW'(NVEC - 1);
  localparam logic [CW-1:0] TOTAL      = CW'(test_len(NSFF, NVEC));

  seq_state_t      state_q;
  logic [SW-1:0]   step_q;
  logic [IW-1:0]   vec_q;
  logic [CW-1:0]   cyc_q;
  logic [NSFF-1:0] load_view;

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q <= ST_IDLE;
      step_q  <= '0;
      vec_q   <= '0;
      cyc_q   <= '0;
    end else begin
      if (busy) cyc_q <= cyc_q + 1'b1;
      case (state_q)
        ST_IDLE, ST_DONE: begin
          if (start) begin
            state_q <= ST_FLUSH;
            step_q  <= '0;
            vec_q   <= '0;
            cyc_q   <= '0;
          end
        end
        ST_FLUSH: begin
          if (step_q == FLUSH_LAST) begin
            state_q <= ST_LOAD;
            step_q  <= '0;
          end else begin
            step_q <= step_q + 1'b1;
          end
        end
        ST_LOAD: begin
          if (step_q == SHIFT_LAST) begin
            state_q <= ST_CAPT;
            step_q  <= '0;
          end else begin
            step_q <= step_q + 1'b1;
          end
        end
        ST_CAPT: begin
          if (vec_q == VEC_LAST) begin
            state_q <= ST_UNLOAD;
          end else begin
            vec_q   <= vec_q + 1'b1;
            state_q <= ST_LOAD;
          end
        end
        ST_UNLOAD: begin
          if (step_q == SHIFT_LAST) state_q <= ST_DONE;
          else                      step_q  <= step_q + 1'b1;
        end
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  // Top bit of this view is the scan word bit due at the current load step
  assign load_view = vec_scan << step_q;

  always_comb begin
    case (state_q)
      ST_FLUSH: chain_bit = step_q[1];
      ST_LOAD:  chain_bit = load_view[NSFF-1];
      default:  chain_bit = 1'b0;
    endcase
  end

  assign busy      = (state_q == ST_FLUSH) || (state_q == ST_LOAD) ||
                     (state_q == ST_CAPT)  || (state_q == ST_UNLOAD);
  assign scan_en   = busy;
  assign func_en   = (state_q == ST_CAPT);
  assign tsel      = busy && (state_q != ST_CAPT);
  assign done      = (state_q == ST_DONE);
  assign vec_idx   = vec_q;
  assign cycle_cnt = cyc_q;

  // R2
  flush_scan_only_chk: assert property (@(posedge clk) disable iff (rst)
    (state_q == ST_FLUSH) |-> (scan_en && !func_en && tsel));

  // R6
  capt_both_clk_chk: assert property (@(posedge clk) disable iff (rst)
    func_en |-> (scan_en && !tsel));

  // R8
  len_formula_chk: assert property (@(posedge clk) disable iff (rst)
    $rose(done) |-> (cycle_cnt == TOTAL));

  // R9
  count_step_chk: assert property (@(posedge clk) disable iff (rst)
    busy |=> (cycle_cnt == $past(cycle_cnt) + 1'b1));

  // R6
  capt_once_chk: assert property (@(posedge clk) disable iff (rst)
    func_en |=> !func_en);

endmodule

// File: rtl/pscan_test_top.sv
`timescale 1ns/1ps
module pscan_test_top
  import pscan_pkg::*;
#(
  parameter int unsigned NSFF = 8,
  parameter int unsigned NNS  = 4,
  parameter int unsigned NPI  = 4,
  parameter int unsigned NVEC = 5,
  localparam int unsigned CW  = $clog2(test_len(NSFF, NVEC) + 1)
) (
  input  logic           clk,
  input  logic           rst,
  input  logic           start,
  output logic           done,
  output logic           busy,
  output logic           scan_clk_en,
  output logic           func_clk_en,
  output logic           test_sel,
  output logic           chain_in,
  output logic           scan_out,
  output logic [NPI-1:0] pi_drive,
  output logic [NNS-1:0] hold_q,
  output logic [CW-1:0]  cycle_cnt
);

  localparam int unsigned SW = $clog2(NSFF + FLUSH_EXTRA);
  localparam int unsigned IW = (NVEC > 1) ? $clog2(NVEC) : 1;

  logic [IW-1:0]   vec_idx;
  logic [NSFF-1:0] vec_scan;
  logic [NPI-1:0]  vec_pi;

  pscan_seq #(
    .NSFF(NSFF), .NVEC(NVEC), .CW(CW), .SW(SW), .IW(IW)
  ) seq_i (
    .clk       (clk),
    .rst       (rst),
    .start     (start),
    .vec_scan  (vec_scan),
    .vec_idx   (vec_idx),
    .scan_en   (scan_clk_en),
    .func_en   (func_clk_en),
    .tsel      (test_sel),
    .chain_bit (chain_in),
    .done      (done),
    .busy      (busy),
    .cycle_cnt (cycle_cnt)
  );

  pscan_vec_rom #(
    .NVEC(NVEC), .NSFF(NSFF), .NPI(NPI), .IW(IW)
  ) rom_i (
    .idx       (vec_idx),
    .scan_word (vec_scan),
    .pi_word   (vec_pi)
  );

  assign pi_drive = func_clk_en ? vec_pi : '0;

  pscan_cut #(
    .NSFF(NSFF), .NNS(NNS), .NPI(NPI)
  ) cut_i (
    .clk      (clk),
    .rst      (rst),
    .scan_en  (scan_clk_en),
    .func_en  (func_clk_en),
    .tsel     (test_sel),
    .sin      (chain_in),
    .pi       (pi_drive),
    .scan_out (scan_out),
    .hold_q   (hold_q)
  );

  // R1
  rst_quiet_chk: assert property (@(posedge clk)
    $past(rst) |-> (!busy && !done && cycle_cnt == '0 && hold_q == '0));

endmodule

// File: tb/pscan_test_top_tb_top.sv
`timescale 1ns/1ps
module pscan_test_top_tb_top;

  localparam int N     = 8;
  localparam int NH    = 4;
  localparam int NP    = 4;
  localparam int NV    = 5;
  localparam int TOTAL = (NV + 2) * N + NV + 4;
  localparam int CW    = $clog2(TOTAL + 1);

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic          start = 1'b0;
  logic          done, busy, scan_clk_en, func_clk_en, test_sel, chain_in, scan_out;
  logic [NP-1:0] pi_drive;
  logic [NH-1:0] hold_q;
  logic [CW-1:0] cycle_cnt;

  int n_tests = 0;
  int n_fail  = 0;

  logic [N-1:0]  m_sc;
  logic [NH-1:0] m_ns;
  int            act_k;

  always #2 clk = ~clk;

  pscan_test_top #(.NSFF(N), .NNS(NH), .NPI(NP), .NVEC(NV)) dut_i (
    .clk(clk), .rst(rst), .start(start), .done(done), .busy(busy),
    .scan_clk_en(scan_clk_en), .func_clk_en(func_clk_en), .test_sel(test_sel),
    .chain_in(chain_in), .scan_out(scan_out), .pi_drive(pi_drive),
    .hold_q(hold_q), .cycle_cnt(cycle_cnt)
  );

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    n_tests++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  function automatic logic [N-1:0] s_word(input int v);
    return N'(v * 157 + 53);
  endfunction

  function automatic logic [NP-1:0] p_word(input int v);
    return NP'(v * 41 + 7);
  endfunction

  // One active cycle: compare at the falling edge, then advance the model
  task automatic step(input bit e_func, input bit e_tsel, input bit e_in,
                      input logic [NP-1:0] e_pi, input string tag, input int glitch);
    logic [N-1:0]  nsc;
    logic [NH-1:0] nns;
    chk(scan_clk_en == 1'b1, {tag, " scan_clk_en"}, scan_clk_en, 1);
    chk(func_clk_en == e_func, {tag, " func_clk_en"}, func_clk_en, e_func);
    chk(test_sel == e_tsel, {tag, " test_sel"}, test_sel, e_tsel);
    chk(chain_in == e_in, {tag, " chain_in"}, chain_in, e_in);
    chk(pi_drive == e_pi, {tag, " pi_drive"}, pi_drive, e_pi);
    chk(scan_out == m_sc[N-1], "R4/R7 scan_out", scan_out, m_sc[N-1]);
    chk(hold_q == m_ns, "R3/R6 hold_q", hold_q, m_ns);
    chk(int'(cycle_cnt) == act_k, "R8 cycle_cnt", cycle_cnt, act_k);
    chk(busy == 1'b1 && done == 1'b0, "R8 busy", busy, 1);
    if (act_k == glitch) start = 1'b1; // R9 stimulus
    if (e_func) begin
      for (int i = 0; i < N; i++)
        nsc[i] = m_sc[(i + 1) % N] ^ e_pi[i % NP] ^ m_ns[i % NH];
      for (int j = 0; j < NH; j++)
        nns[j] = m_ns[j] ^ e_pi[j % NP] ^ m_sc[j % N];
      m_sc = nsc;
      m_ns = nns;
    end else begin
      m_sc = {m_sc[N-2:0], e_in};
    end
    act_k++;
    @(negedge clk);
    start = 1'b0;
  endtask

  task automatic run_full(input string name, input int glitch);
    logic [N-1:0] w;
    @(negedge clk);
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    act_k = 0;
    for (int f = 0; f < N + 4; f++)
      step(1'b0, 1'b1, f[1], '0, "R2 flush", glitch);
    for (int v = 0; v < NV; v++) begin
      w = s_word(v);
      for (int b = 0; b < N; b++)
        step(1'b0, 1'b1, w[N-1-b], '0, "R5 load", glitch);
      step(1'b1, 1'b0, 1'b0, p_word(v), "R6 capture", glitch);
    end
    for (int b = 0; b < N; b++)
      step(1'b0, 1'b1, 1'b0, '0, "R7 unload", glitch);
    chk(done == 1'b1, {name, " R8 done"}, done, 1);
    chk(busy == 1'b0, {name, " R8 busy low"}, busy, 0);
    chk(int'(cycle_cnt) == TOTAL, {name, " R8 total"}, cycle_cnt, TOTAL);
    chk(scan_out == m_sc[N-1], {name, " R7 final scan_out"}, scan_out, m_sc[N-1]);
    chk(hold_q == m_ns, {name, " R3 final hold_q"}, hold_q, m_ns);
  endtask

  task automatic t_reset();
    chk(done == 0 && busy == 0, "R1 done/busy", {done, busy}, 0);
    chk(scan_clk_en == 0 && func_clk_en == 0, "R1 enables", {scan_clk_en, func_clk_en}, 0);
    chk(test_sel == 0 && chain_in == 0, "R1 sel/in", {test_sel, chain_in}, 0);
    chk(scan_out == 0, "R1 scan_out", scan_out, 0);
    chk(pi_drive == 0, "R1 pi_drive", pi_drive, 0);
    chk(hold_q == 0, "R1 hold_q", hold_q, 0);
    chk(cycle_cnt == 0, "R1 cycle_cnt", cycle_cnt, 0);
  endtask

  task automatic t_done_hold();
    logic [NH-1:0] h;
    h = hold_q;
    repeat (5) @(negedge clk);
    chk(done == 1'b1, "R8 done held", done, 1);
    chk(int'(cycle_cnt) == TOTAL, "R8 count held", cycle_cnt, TOTAL);
    chk(hold_q == h, "R3 idle hold_q", hold_q, h);
    chk(scan_clk_en == 0 && func_clk_en == 0, "R3 idle enables", {scan_clk_en, func_clk_en}, 0);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_tests++;
    n_fail++;
    $display("FAIL watchdog: actual timeout expected finish");
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    m_sc = '0;
    m_ns = '0;
    act_k = 0;
    repeat (3) @(negedge clk);
    t_reset();
    rst = 1'b0;
    @(negedge clk);
    t_reset();
    run_full("run1", -1);
    t_done_hold();
    // R10: restart from done keeps non-scanned state; R9: start pulses mid-run
    run_full("run2 R10 R9", 3);
    run_full("run3 R9", TOTAL - 2);
    t_done_hold();
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

endmodule